// File: doc/BRIEF.md
# Retirement Redundancy Checker with Rewind Sequencer

This block sits at the retire stage of the trailing core in a leader/trailer core pair. For each retiring instruction it compares the trailing core's result with a second copy of the same result. A per-instruction flag tells it where the second copy comes from. When the flag is clear, the leading core produced a trustworthy value, and that value costs nothing extra. When the flag is set, the leading core had no valid value, so the trailing core ran the instruction a second time and the second run's result is used.

A disagreement is treated as a transient fault and takes the same recovery path as a branch misprediction. The block steps through a fixed rewind sequence:

- squash both cores;
- empty the queue that links the two cores;
- copy the architectural registers from the trailing core into the leading core, one register per cycle in ascending order;
- invalidate the leading core's speculative store cache.

Retirement is held off for the whole sequence. A saturating counter records every detected fault. The block also releases the scratch destination register used by a second execution once the comparison for that instruction is done.

Top module: `rrc_top`

## Requirements
- R1: With `retireFrontInv` = 0, an accepted retire is checked against `frontResult`; `secondResult` has no effect.
- R2: With `retireFrontInv` = 1, an accepted retire is checked against `secondResult`; `frontResult` has no effect.
- R3: An accepted retire whose result differs from its reference makes `squashAll` high for exactly one cycle, starting in the cycle after the retire.
- R4: Rewind order:
  - `squashAll` for one cycle;
  - then `flushQueue` for one cycle;
  - then `copyRegValid` for NUM_REGS cycles, with `copyRegIndex` counting 0 up to NUM_REGS-1;
  - then `invalidateCache` for one cycle;
  - then idle.
  
  At most one of these strobes is high at any time.
- R5: `mispredict` seen while idle starts the same rewind in the next cycle and does not change `faultCount`.
- R6: `retireStall` is high in every cycle of a rewind. During a rewind, retire requests and `mispredict` are ignored: they neither count a fault nor start a further rewind.
- R7: `faultCount` rises by exactly one for each detected mismatch, one cycle after it, and saturates at its maximum value.
- R8: An accepted retire with `retireFrontInv` = 1 raises `freeValid` in the next cycle, with `freeTag` equal to that retire's `redunTag`. A retire with the flag clear frees nothing.
- R9: After reset, all strobes, `retireStall` and `freeValid` are low and `faultCount` is zero.
- R10: A mismatch and `mispredict` in the same idle cycle start one single rewind and count one fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| retireValid | input | 1 | An instruction is presented for retirement |
| retireResult | input | DATA_W | Trailing core's result |
| retireFrontInv | input | 1 | Leading core had no valid result for this instruction |
| frontResult | input | DATA_W | Leading core's result |
| secondResult | input | DATA_W | Result of the trailing core's second execution |
| redunTag | input | TAG_W | Scratch destination register of the second execution |
| mispredict | input | 1 | Branch misprediction detected |
| retireStall | output | 1 | Retirement held off during a rewind |
| squashAll | output | 1 | Squash both cores |
| flushQueue | output | 1 | Empty the inter-core result queue |
| copyRegValid | output | 1 | Register copy in progress this cycle |
| copyRegIndex | output | IDX_W | Register being copied |
| invalidateCache | output | 1 | Invalidate the speculative store cache |
| faultCount | output | CNT_W | Saturating count of detected faults |
| freeValid | output | 1 | Release a scratch destination register |
| freeTag | output | TAG_W | Register being released |

## Verification
The hardest situation to create from the ports is counter saturation, because it needs 255 complete rewinds in a row. The bench reaches it with a loop of mismatching retires, each waiting for the rewind to finish, and then adds one more fault to confirm the count holds at its maximum. A second hard case is the R6 rule that inputs arriving during a rewind are ignored. The bench holds a mismatching retire and a mispredict on the inputs for the whole sequence. It then confirms that the count is unchanged and that no second squash follows.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SQUASH,
    ST_FLUSH,
    ST_COPY,
    ST_INVAL
  } recState_t;

  typedef struct packed {
    logic retireAccept;
    logic countFault;
    logic squash;
    logic flushQueue;
    logic copyRegs;
    logic invCache;
  } ctrlStrobe_t;
endpackage

// File: rtl/rrc_datapath.sv
module rrc_datapath
  import rrc_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int TAG_W    = 6,
  parameter int CNT_W    = 8,
  parameter int LANE_W   = 8,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] retireResult,
  input  logic              retireFrontInv,
  input  logic [DATA_W-1:0] frontResult,
  input  logic [DATA_W-1:0] secondResult,
  input  logic [TAG_W-1:0]  redunTag,
  output logic              mismatch,
  output logic              copyLast,
  output logic [IDX_W-1:0]  copyIndex,
  output logic [CNT_W-1:0]  faultCount,
  output logic              freeValid,
  output logic [TAG_W-1:0]  freeTag
);
  localparam int NUM_LANES = (DATA_W + LANE_W - 1) / LANE_W;
  localparam int PAD_W     = NUM_LANES * LANE_W;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_REGS - 1);

  logic [DATA_W-1:0]    refResult;
  logic [PAD_W-1:0]     padRetire;
  logic [PAD_W-1:0]     padRef;
  logic [NUM_LANES-1:0] laneDiff;

  // Pick the reference copy: second execution when the leader's value is invalid.
  assign refResult = retireFrontInv ? secondResult : frontResult;
  assign padRetire = PAD_W'(retireResult);
  assign padRef    = PAD_W'(refResult);

  // Lane-wise compare keeps the reduction tree shallow for wide results.
  for (genvar lane = 0; lane < NUM_LANES; lane++) begin : g_lane
    assign laneDiff[lane] =
      |(padRetire[lane*LANE_W +: LANE_W] ^ padRef[lane*LANE_W +: LANE_W]);
  end

  assign mismatch = |laneDiff;
  assign copyLast = (copyIndex == IDX_LAST);

  // Register copy index: walks up while the copy strobe is active.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      copyIndex <= '0;
    end else if (strobe.copyRegs && !copyLast) begin
      copyIndex <= copyIndex + 1'b1;
    end else begin
      copyIndex <= '0;
    end
  end

  // Saturating fault counter.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultCount <= '0;
    end else if (strobe.countFault && (faultCount != CNT_MAX)) begin
      faultCount <= faultCount + 1'b1;
    end
  end

  // Scratch destination release, one cycle after the comparison.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      freeValid <= 1'b0;
      freeTag   <= '0;
    end else begin
      freeValid <= strobe.retireAccept && retireFrontInv;
      if (strobe.retireAccept && retireFrontInv) begin
        freeTag <= redunTag;
      end
    end
  end
endmodule

// File: rtl/rrc_ctrl.sv
module rrc_ctrl
  import rrc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        retireValid,
  input  logic        mispredict,
  input  logic        mismatch,
  input  logic        copyLast,
  output ctrlStrobe_t strobe,
  output logic        retireStall
);
  recState_t state;
  recState_t stateNext;
  logic      idle;
  logic      accept;
  logic      fault;

  assign idle   = (state == ST_IDLE);
  assign accept = idle && retireValid;
  assign fault  = accept && mismatch;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (fault || mispredict) stateNext = ST_SQUASH;
      ST_SQUASH: stateNext = ST_FLUSH;
      ST_FLUSH:  stateNext = ST_COPY;
      ST_COPY:   if (copyLast) stateNext = ST_INVAL;
      ST_INVAL:  stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe              = '0;
    strobe.retireAccept = accept;
    strobe.countFault   = fault;
    strobe.squash       = (state == ST_SQUASH);
    strobe.flushQueue   = (state == ST_FLUSH);
    strobe.copyRegs     = (state == ST_COPY);
    strobe.invCache     = (state == ST_INVAL);
  end

  assign retireStall = !idle;
endmodule

// File: rtl/rrc_top.sv
module rrc_top
  import rrc_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int TAG_W    = 6,
  parameter int CNT_W    = 8,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              retireValid,
  input  logic [DATA_W-1:0] retireResult,
  input  logic              retireFrontInv,
  input  logic [DATA_W-1:0] frontResult,
  input  logic [DATA_W-1:0] secondResult,
  input  logic [TAG_W-1:0]  redunTag,
  input  logic              mispredict,
  output logic              retireStall,
  output logic              squashAll,
  output logic              flushQueue,
  output logic              copyRegValid,
  output logic [IDX_W-1:0]  copyRegIndex,
  output logic              invalidateCache,
  output logic [CNT_W-1:0]  faultCount,
  output logic              freeValid,
  output logic [TAG_W-1:0]  freeTag
);
  ctrlStrobe_t strobe;
  logic        mismatch;
  logic        copyLast;

  rrc_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .retireValid (retireValid),
    .mispredict  (mispredict),
    .mismatch    (mismatch),
    .copyLast    (copyLast),
    .strobe      (strobe),
    .retireStall (retireStall)
  );

  rrc_datapath #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .TAG_W    (TAG_W),
    .CNT_W    (CNT_W)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .retireResult   (retireResult),
    .retireFrontInv (retireFrontInv),
    .frontResult    (frontResult),
    .secondResult   (secondResult),
    .redunTag       (redunTag),
    .mismatch       (mismatch),
    .copyLast       (copyLast),
    .copyIndex      (copyRegIndex),
    .faultCount     (faultCount),
    .freeValid      (freeValid),
    .freeTag        (freeTag)
  );

  assign squashAll       = strobe.squash;
  assign flushQueue      = strobe.flushQueue;
  assign copyRegValid    = strobe.copyRegs;
  assign invalidateCache = strobe.invCache;
endmodule

// File: rtl/rrc_checker.sv
module rrc_checker #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int TAG_W    = 6,
  parameter int CNT_W    = 8,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              retireValid,
  input logic [DATA_W-1:0] retireResult,
  input logic              retireFrontInv,
  input logic [DATA_W-1:0] frontResult,
  input logic [DATA_W-1:0] secondResult,
  input logic [TAG_W-1:0]  redunTag,
  input logic              mispredict,
  input logic              retireStall,
  input logic              squashAll,
  input logic              flushQueue,
  input logic              copyRegValid,
  input logic [IDX_W-1:0]  copyRegIndex,
  input logic              invalidateCache,
  input logic [CNT_W-1:0]  faultCount,
  input logic              freeValid,
  input logic [TAG_W-1:0]  freeTag
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_REGS - 1);

  p_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({squashAll, flushQueue, copyRegValid, invalidateCache}));

  p_squash_flush_r4: assert property (@(posedge clk) disable iff (!rstN)
    squashAll |=> flushQueue);

  p_flush_copy_r4: assert property (@(posedge clk) disable iff (!rstN)
    flushQueue |=> (copyRegValid && copyRegIndex == '0));

  p_copy_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (copyRegValid && copyRegIndex != LAST) |=>
      (copyRegValid && copyRegIndex == IDX_W'($past(copyRegIndex) + 1'b1)));

  p_copy_end_r4: assert property (@(posedge clk) disable iff (!rstN)
    (copyRegValid && copyRegIndex == LAST) |=> invalidateCache);

  p_stall_r6: assert property (@(posedge clk) disable iff (!rstN)
    (squashAll || flushQueue || copyRegValid || invalidateCache) |-> retireStall);

  p_mismatch_r3: assert property (@(posedge clk) disable iff (!rstN)
    (retireValid && !retireStall && !retireFrontInv && retireResult != frontResult)
      |=> squashAll);

  p_count_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (faultCount != $past(faultCount)) |-> (faultCount == CNT_W'($past(faultCount) + 1'b1)));

  p_free_r8: assert property (@(posedge clk) disable iff (!rstN)
    (retireValid && !retireStall && retireFrontInv) |=> (freeValid && freeTag == $past(redunTag)));

  p_mispredict_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mispredict && !retireStall) |=> squashAll);
endmodule

bind rrc_top rrc_checker #(
  .DATA_W   (DATA_W),
  .NUM_REGS (NUM_REGS),
  .TAG_W    (TAG_W),
  .CNT_W    (CNT_W)
) u_chk (
  .clk             (clk),
  .rstN            (rstN),
  .retireValid     (retireValid),
  .retireResult    (retireResult),
  .retireFrontInv  (retireFrontInv),
  .frontResult     (frontResult),
  .secondResult    (secondResult),
  .redunTag        (redunTag),
  .mispredict      (mispredict),
  .retireStall     (retireStall),
  .squashAll       (squashAll),
  .flushQueue      (flushQueue),
  .copyRegValid    (copyRegValid),
  .copyRegIndex    (copyRegIndex),
  .invalidateCache (invalidateCache),
  .faultCount      (faultCount),
  .freeValid       (freeValid),
  .freeTag         (freeTag)
);

// File: tb/tb_rrc_top.sv
module tb_rrc_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 32;
  localparam int NUM_REGS   = 8;
  localparam int TAG_W      = 6;
  localparam int CNT_W      = 8;
  localparam int IDX_W      = $clog2(NUM_REGS);
  localparam int CNT_MAX    = (1 << CNT_W) - 1;
  localparam int WATCHDOG   = 150000;

  logic              clk = 1'b0;
  logic              rstN;
  logic              retireValid;
  logic [DATA_W-1:0] retireResult;
  logic              retireFrontInv;
  logic [DATA_W-1:0] frontResult;
  logic [DATA_W-1:0] secondResult;
  logic [TAG_W-1:0]  redunTag;
  logic              mispredict;
  logic              retireStall;
  logic              squashAll;
  logic              flushQueue;
  logic              copyRegValid;
  logic [IDX_W-1:0]  copyRegIndex;
  logic              invalidateCache;
  logic [CNT_W-1:0]  faultCount;
  logic              freeValid;
  logic [TAG_W-1:0]  freeTag;

  int checks = 0;
  int errors = 0;
  int expCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rrc_top #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .CNT_W(CNT_W)
  ) dut (
    .clk(clk), .rstN(rstN), .retireValid(retireValid), .retireResult(retireResult),
    .retireFrontInv(retireFrontInv), .frontResult(frontResult),
    .secondResult(secondResult), .redunTag(redunTag), .mispredict(mispredict),
    .retireStall(retireStall), .squashAll(squashAll), .flushQueue(flushQueue),
    .copyRegValid(copyRegValid), .copyRegIndex(copyRegIndex),
    .invalidateCache(invalidateCache), .faultCount(faultCount),
    .freeValid(freeValid), .freeTag(freeTag)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clearInputs();
    retireValid = 0; retireResult = '0; retireFrontInv = 0;
    frontResult = '0; secondResult = '0; redunTag = '0; mispredict = 0;
  endtask

  // Present one request at a negedge, then step to the next negedge and clear.
  task automatic present(input logic v, input logic [DATA_W-1:0] res, input logic fInv,
                         input logic [DATA_W-1:0] fr, input logic [DATA_W-1:0] sec,
                         input logic [TAG_W-1:0] tag, input logic mp);
    retireValid = v; retireResult = res; retireFrontInv = fInv;
    frontResult = fr; secondResult = sec; redunTag = tag; mispredict = mp;
    @(negedge clk);
    clearInputs();
  endtask

  task automatic checkIdle(input string req);
    check(req, "squashAll idle", squashAll, 0);
    check(req, "retireStall idle", retireStall, 0);
    check(req, "flushQueue idle", flushQueue, 0);
    check(req, "copyRegValid idle", copyRegValid, 0);
    check(req, "invalidateCache idle", invalidateCache, 0);
  endtask

  // Called at the first negedge after the triggering edge; ends at the idle cycle.
  task automatic checkRewind(input string req);
    check(req, "squashAll", squashAll, 1);
    check("R6", "stall in squash", retireStall, 1);
    @(negedge clk);
    check("R4", "squash one cycle", squashAll, 0);
    check("R4", "flushQueue", flushQueue, 1);
    for (int k = 0; k < NUM_REGS; k++) begin
      @(negedge clk);
      check("R4", "copyRegValid", copyRegValid, 1);
      check("R4", "copyRegIndex", copyRegIndex, k);
      check("R6", "stall in copy", retireStall, 1);
    end
    @(negedge clk);
    check("R4", "invalidateCache", invalidateCache, 1);
    check("R4", "copy ended", copyRegValid, 0);
    @(negedge clk);
    checkIdle("R4");
  endtask

  task automatic testReset();
    checkIdle("R9");
    check("R9", "faultCount", faultCount, 0);
    check("R9", "freeValid", freeValid, 0);
  endtask

  task automatic testMatchFront();
    present(1, 32'hA5A5_0001, 0, 32'hA5A5_0001, 32'hDEAD_BEEF, 6'd3, 0);
    check("R1", "no squash on front match", squashAll, 0);
    check("R1", "faultCount", faultCount, expCount);
    check("R8", "no free with flag clear", freeValid, 0);
  endtask

  task automatic testMatchSecond();
    present(1, 32'h1234_5678, 1, 32'h0BAD_0BAD, 32'h1234_5678, 6'd17, 0);
    check("R2", "no squash on second match", squashAll, 0);
    check("R2", "faultCount", faultCount, expCount);
    check("R8", "freeValid", freeValid, 1);
    check("R8", "freeTag", freeTag, 17);
    @(negedge clk);
    check("R8", "free is one cycle", freeValid, 0);
  endtask

  task automatic testMismatchFront();
    present(1, 32'h0000_00FF, 0, 32'h0000_00FE, 32'h0000_00FF, 6'd5, 0);
    expCount++;
    check("R7", "count after fault", faultCount, expCount);
    check("R8", "no free", freeValid, 0);
    checkRewind("R3");
    check("R1", "count stable", faultCount, expCount);
  endtask

  task automatic testMismatchSecond();
    present(1, 32'hCAFE_0000, 1, 32'hCAFE_0000, 32'hCAFE_0001, 6'd42, 0);
    expCount++;
    check("R8", "freeValid on mismatch", freeValid, 1);
    check("R8", "freeTag", freeTag, 42);
    check("R7", "count after fault", faultCount, expCount);
    checkRewind("R2");
  endtask

  task automatic testMispredict();
    present(0, '0, 0, '0, '0, '0, 1);
    check("R5", "count unchanged", faultCount, expCount);
    checkRewind("R5");
  endtask

  task automatic testIgnoredDuringRewind();
    present(0, '0, 0, '0, '0, '0, 1);
    retireValid = 1; retireResult = 32'h1; retireFrontInv = 0;
    frontResult = 32'h2; mispredict = 1;
    checkRewind("R6");
    clearInputs();
    @(negedge clk);
    check("R6", "no second rewind", squashAll, 0);
    check("R6", "count unchanged", faultCount, expCount);
  endtask

  task automatic testBoth();
    present(1, 32'h77, 0, 32'h78, '0, '0, 1);
    expCount++;
    check("R10", "count once", faultCount, expCount);
    checkRewind("R10");
    @(negedge clk);
    check("R10", "single rewind", squashAll, 0);
    check("R10", "count stable", faultCount, expCount);
  endtask

  task automatic testSaturate();
    while (expCount < CNT_MAX) begin
      present(1, 32'h10, 0, 32'h11, '0, '0, 0);
      expCount++;
      repeat (NUM_REGS + 3) @(negedge clk);
    end
    check("R7", "count at max", faultCount, CNT_MAX);
    present(1, 32'h10, 0, 32'h11, '0, '0, 0);
    check("R7", "saturated squash", squashAll, 1);
    repeat (NUM_REGS + 3) @(negedge clk);
    check("R7", "count saturated", faultCount, CNT_MAX);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=<%0d cycles", cyc, WATCHDOG);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clearInputs();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testMatchFront();
    testMatchSecond();
    testMismatchFront();
    testMismatchSecond();
    testMispredict();
    testIgnoredDuringRewind();
    testBoth();
    testSaturate();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule